// File: doc/BRIEF.md
# Program Counter Update and Exception Capture Unit

This block holds the program counter of a multicycle processor and decides, once per clock, whether and from where it is reloaded. A sequencer outside the block drives an unconditional load strobe, a conditional load strobe qualified by the ALU zero flag (or its inverse, for branch-if-not-equal), and a 3-bit source code. The source code picks one of five next values: the live ALU result, the registered ALU output, a jump target built from the current PC and the instruction index field, a fixed handler address, or the saved exception PC.

The unit also keeps two exception registers. On exception entry the sequencer strobes the exception PC register to capture the ALU result, which the ALU has formed as the address of the faulting instruction. In the same cycle it strobes the cause register to record a one-bit cause code. Returning from a handler selects the saved exception PC as the next PC. The control sequencer and the ALU themselves are not part of this block.

Top module: `pc_unit`

## Requirements
- R1: A synchronous active-high reset clears the PC, the exception PC and the cause register to zero. Reset takes priority over every load strobe.
- R2: With both `pcWrite` and `pcWriteCond` low, the PC holds its value. With `pcWrite` high, the PC loads the selected source on the clock edge.
- R3: With `pcWrite` low, `pcWriteCond` high and `branchNe` low, the PC loads the selected source only when `aluZero` is 1.
- R4: With `pcWrite` low, `pcWriteCond` high and `branchNe` high, the PC loads the selected source only when `aluZero` is 0.
- R5: `pcSrc` code 3'b000 selects `aluResult`, 3'b001 selects `aluOut`, and 3'b010 selects the jump target. The jump target is `{pc[31:28], instrIndex[25:0], 2'b00}`.
- R6: `pcSrc` code 3'b011 selects the fixed handler address 0xC000_0000.
- R7: `pcSrc` code 3'b100 selects the exception PC value held before the clock edge.
- R8: `pcSrc` codes 3'b101, 3'b110 and 3'b111 leave the PC unchanged even when a load strobe is active.
- R9: With `epcWrite` high, the exception PC captures `aluResult`. Otherwise it holds its value.
- R10: With `causeWrite` high, the cause register stores `intCause` in bit 0 and zero in bits 31:1. The code is 0 for an undefined opcode and 1 for arithmetic overflow. Otherwise the register holds its value.
- R11: When a PC load and an exception PC capture happen in the same cycle, each register uses the values present before the edge. This applies both to handler entry (source 3'b011) and to a return while capturing (source 3'b100).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| aluResult | input | 32 | Combinational ALU result |
| aluOut | input | 32 | Registered ALU output (branch target) |
| instrIndex | input | 26 | Instruction index field for jumps |
| aluZero | input | 1 | ALU zero flag |
| pcWrite | input | 1 | Unconditional PC load |
| pcWriteCond | input | 1 | Conditional PC load |
| branchNe | input | 1 | 0: branch on zero, 1: branch on non-zero |
| pcSrc | input | 3 | Next-PC source select |
| epcWrite | input | 1 | Capture aluResult into exception PC |
| causeWrite | input | 1 | Record intCause into cause register |
| intCause | input | 1 | Cause code: 0 undefined opcode, 1 overflow |
| pc | output | 32 | Current program counter |
| epc | output | 32 | Saved exception PC |
| cause | output | 32 | Cause register, only bit 0 used |

## Verification
Two functions can fall in the same cycle: redirecting the PC and capturing the exception PC. This happens on handler entry, where the PC goes to the handler while the exception PC takes the faulting address. It also happens when a return from exception is issued with `epcWrite` still asserted. The bench provokes both cases with stimulus vectors. It then judges that the PC took the old exception PC or the handler address, while the exception PC took the new ALU result, both in the same edge. It also checks that a reset applied together with a load strobe wins.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    SRC_ALU     = 3'b000,
    SRC_ALUREG  = 3'b001,
    SRC_JUMP    = 3'b010,
    SRC_HANDLER = 3'b011,
    SRC_EPC     = 3'b100
  } pcSrcT;

  typedef struct packed {
    logic  pcLoad;
    logic  epcLoad;
    logic  causeLoad;
    pcSrcT src;
    logic  srcValid;
  } pcuStrobeT;

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic       pcWrite,
  input  logic       pcWriteCond,
  input  logic       branchNe,
  input  logic       aluZero,
  input  logic [2:0] pcSrc,
  input  logic       epcWrite,
  input  logic       causeWrite,
  output pcuStrobeT  strobes
);

  logic branchTaken;
  logic srcKnown;

  // branch condition: zero flag, or its inverse for not-equal
  assign branchTaken = branchNe ? ~aluZero : aluZero;

  always_comb begin
    srcKnown = 1'b0;
    case (pcSrc)
      SRC_ALU, SRC_ALUREG, SRC_JUMP, SRC_HANDLER, SRC_EPC: srcKnown = 1'b1;
      default: srcKnown = 1'b0;
    endcase
  end

  always_comb begin
    strobes           = '0;
    strobes.src       = pcSrcT'(pcSrc);
    strobes.srcValid  = srcKnown;
    strobes.pcLoad    = srcKnown & (pcWrite | (pcWriteCond & branchTaken));
    strobes.epcLoad   = epcWrite;
    strobes.causeLoad = causeWrite;
  end

endmodule

// File: rtl/pcu_dpath.sv
module pcu_dpath
  import pcu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 26,
  parameter int CAUSE_W = 1,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 32'hC000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  pcuStrobeT          strobes,
  input  logic [DATA_W-1:0]  aluResult,
  input  logic [DATA_W-1:0]  aluOut,
  input  logic [INDEX_W-1:0] instrIndex,
  input  logic [CAUSE_W-1:0] intCause,
  output logic [DATA_W-1:0]  pcQ,
  output logic [DATA_W-1:0]  epcQ,
  output logic [DATA_W-1:0]  causeQ
);

  localparam int UPPER_W = DATA_W - INDEX_W - 2;

  logic [DATA_W-1:0]  jumpTarget;
  logic [DATA_W-1:0]  nextPc;
  logic [CAUSE_W-1:0] causeCode;

  assign jumpTarget = {pcQ[DATA_W-1 -: UPPER_W], instrIndex, 2'b00};

  always_comb begin
    nextPc = pcQ;
    case (strobes.src)
      SRC_ALU:     nextPc = aluResult;
      SRC_ALUREG:  nextPc = aluOut;
      SRC_JUMP:    nextPc = jumpTarget;
      SRC_HANDLER: nextPc = HANDLER_ADDR;
      SRC_EPC:     nextPc = epcQ;
      default:     nextPc = pcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ       <= '0;
      epcQ      <= '0;
      causeCode <= '0;
    end else begin
      if (strobes.pcLoad)    pcQ       <= nextPc;
      if (strobes.epcLoad)   epcQ      <= aluResult;
      if (strobes.causeLoad) causeCode <= intCause;
    end
  end

  generate
    if (CAUSE_W < DATA_W) begin : gCausePad
      assign causeQ = {{(DATA_W-CAUSE_W){1'b0}}, causeCode};
    end else begin : gCauseFull
      assign causeQ = causeCode[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pcu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 26,
  parameter int CAUSE_W = 1,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 32'hC000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  aluResult,
  input  logic [DATA_W-1:0]  aluOut,
  input  logic [INDEX_W-1:0] instrIndex,
  input  logic               aluZero,
  input  logic               pcWrite,
  input  logic               pcWriteCond,
  input  logic               branchNe,
  input  logic [2:0]         pcSrc,
  input  logic               epcWrite,
  input  logic               causeWrite,
  input  logic [CAUSE_W-1:0] intCause,
  output logic [DATA_W-1:0]  pc,
  output logic [DATA_W-1:0]  epc,
  output logic [DATA_W-1:0]  cause
);

  pcuStrobeT strobes;

  pcu_ctrl uCtrl (
    .pcWrite    (pcWrite),
    .pcWriteCond(pcWriteCond),
    .branchNe   (branchNe),
    .aluZero    (aluZero),
    .pcSrc      (pcSrc),
    .epcWrite   (epcWrite),
    .causeWrite (causeWrite),
    .strobes    (strobes)
  );

  pcu_dpath #(
    .DATA_W      (DATA_W),
    .INDEX_W     (INDEX_W),
    .CAUSE_W     (CAUSE_W),
    .HANDLER_ADDR(HANDLER_ADDR)
  ) uDpath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .aluResult (aluResult),
    .aluOut    (aluOut),
    .instrIndex(instrIndex),
    .intCause  (intCause),
    .pcQ       (pc),
    .epcQ      (epc),
    .causeQ    (cause)
  );

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 1,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 32'hC000_0000
) (
  input logic               clk,
  input logic               rst,
  input logic [DATA_W-1:0]  aluResult,
  input logic               aluZero,
  input logic               pcWrite,
  input logic               pcWriteCond,
  input logic               branchNe,
  input logic [2:0]         pcSrc,
  input logic               epcWrite,
  input logic               causeWrite,
  input logic [CAUSE_W-1:0] intCause,
  input logic [DATA_W-1:0]  pc,
  input logic [DATA_W-1:0]  epc,
  input logic [DATA_W-1:0]  cause
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && epc == '0 && cause == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!pcWrite && !pcWriteCond) |=> $stable(pc));

  assert_cond_false_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!pcWrite && pcWriteCond && (aluZero == branchNe)) |=> $stable(pc));

  assert_handler_R6: assert property (@(posedge clk) disable iff (rst)
    (pcWrite && pcSrc == 3'b011) |=> (pc == HANDLER_ADDR));

  assert_return_epc_R7: assert property (@(posedge clk) disable iff (rst)
    (pcWrite && pcSrc == 3'b100) |=> (pc == $past(epc)));

  assert_unused_src_R8: assert property (@(posedge clk) disable iff (rst)
    (pcSrc[2] && pcSrc[1:0] != 2'b00) |=> $stable(pc));

  assert_epc_capture_R9: assert property (@(posedge clk) disable iff (rst)
    epcWrite |=> (epc == $past(aluResult)));

  assert_epc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !epcWrite |=> $stable(epc));

  assert_cause_record_R10: assert property (@(posedge clk) disable iff (rst)
    causeWrite |=> (cause == DATA_W'($past(intCause))));

  assert_cause_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !causeWrite |=> $stable(cause));

endmodule

bind pc_unit pcu_checker #(
  .DATA_W      (DATA_W),
  .CAUSE_W     (CAUSE_W),
  .HANDLER_ADDR(HANDLER_ADDR)
) uChecker (
  .clk        (clk),
  .rst        (rst),
  .aluResult  (aluResult),
  .aluZero    (aluZero),
  .pcWrite    (pcWrite),
  .pcWriteCond(pcWriteCond),
  .branchNe   (branchNe),
  .pcSrc      (pcSrc),
  .epcWrite   (epcWrite),
  .causeWrite (causeWrite),
  .intCause   (intCause),
  .pc         (pc),
  .epc        (epc),
  .cause      (cause)
);

// File: tb/tb_pc_unit.sv
module tb_pc_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] aluResult, aluOut;
  logic [25:0] instrIndex;
  logic        aluZero, pcWrite, pcWriteCond, branchNe;
  logic [2:0]  pcSrc;
  logic        epcWrite, causeWrite;
  logic [0:0]  intCause;
  logic [31:0] pc, epc, cause;

  int applied = 0;
  int misses  = 0;

  always #5 clk = ~clk;

  pc_unit dut (
    .clk(clk), .rst(rst), .aluResult(aluResult), .aluOut(aluOut),
    .instrIndex(instrIndex), .aluZero(aluZero), .pcWrite(pcWrite),
    .pcWriteCond(pcWriteCond), .branchNe(branchNe), .pcSrc(pcSrc),
    .epcWrite(epcWrite), .causeWrite(causeWrite), .intCause(intCause),
    .pc(pc), .epc(epc), .cause(cause)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        pw, cond, ne, zero;
    logic [2:0]  src;
    logic        ew, cw, ic;
    logic [31:0] ar, ao;
    logic [25:0] idx;
    logic [31:0] expPc, expEpc, expCause;
  } vecT;

  localparam int NV = 18;
  // req  pw cond ne z  src  ew cw ic  aluResult     aluOut        idx          pc            epc           cause
  localparam vecT VEC [NV] = '{
    '{8'd5,  1,0,0,0, 3'd0, 0,0,0, 32'h0000_0004, 32'h0,        26'h0,       32'h0000_0004, 32'h0,        32'h0}, // R5 alu
    '{8'd2,  0,0,0,0, 3'd0, 0,0,0, 32'h0000_0100, 32'h0,        26'h0,       32'h0000_0004, 32'h0,        32'h0}, // R2 hold
    '{8'd5,  1,0,0,0, 3'd1, 0,0,0, 32'h0,         32'h0000_0040,26'h0,       32'h0000_0040, 32'h0,        32'h0}, // R5 aluOut
    '{8'd3,  0,1,0,0, 3'd1, 0,0,0, 32'h0,         32'h0000_0080,26'h0,       32'h0000_0040, 32'h0,        32'h0}, // R3 not taken
    '{8'd3,  0,1,0,1, 3'd1, 0,0,0, 32'h0,         32'h0000_0080,26'h0,       32'h0000_0080, 32'h0,        32'h0}, // R3 taken
    '{8'd4,  0,1,1,1, 3'd1, 0,0,0, 32'h0,         32'h0000_0200,26'h0,       32'h0000_0080, 32'h0,        32'h0}, // R4 not taken
    '{8'd4,  0,1,1,0, 3'd1, 0,0,0, 32'h0,         32'h0000_0200,26'h0,       32'h0000_0200, 32'h0,        32'h0}, // R4 taken
    '{8'd5,  1,0,0,0, 3'd0, 0,0,0, 32'h3000_0010, 32'h0,        26'h0,       32'h3000_0010, 32'h0,        32'h0}, // R5 alu
    '{8'd5,  1,0,0,0, 3'd2, 0,0,0, 32'h0,         32'h0,        26'h0ABCDEF, 32'h32AF_37BC, 32'h0,        32'h0}, // R5 jump
    '{8'd11, 1,0,0,0, 3'd3, 1,1,1, 32'h32AF_37B8, 32'h0,        26'h0,       32'hC000_0000, 32'h32AF_37B8,32'h1}, // R11 R6 entry
    '{8'd9,  1,0,0,0, 3'd0, 0,0,0, 32'hC000_0004, 32'h0,        26'h0,       32'hC000_0004, 32'h32AF_37B8,32'h1}, // R9 hold
    '{8'd10, 0,0,0,0, 3'd0, 0,1,0, 32'h0,         32'h0,        26'h0,       32'hC000_0004, 32'h32AF_37B8,32'h0}, // R10 opcode
    '{8'd7,  1,0,0,0, 3'd4, 0,0,0, 32'h0,         32'h0,        26'h0,       32'h32AF_37B8, 32'h32AF_37B8,32'h0}, // R7 return
    '{8'd8,  1,0,0,0, 3'd5, 0,0,0, 32'h5555_5555, 32'h0,        26'h0,       32'h32AF_37B8, 32'h32AF_37B8,32'h0}, // R8 code 5
    '{8'd8,  1,0,0,0, 3'd6, 0,0,0, 32'h5555_5555, 32'h0,        26'h0,       32'h32AF_37B8, 32'h32AF_37B8,32'h0}, // R8 code 6
    '{8'd8,  0,1,0,1, 3'd7, 0,0,0, 32'h5555_5555, 32'h0,        26'h0,       32'h32AF_37B8, 32'h32AF_37B8,32'h0}, // R8 code 7
    '{8'd11, 1,0,0,0, 3'd4, 1,0,0, 32'h0000_1234, 32'h0,        26'h0,       32'h32AF_37B8, 32'h0000_1234,32'h0}, // R11 return+capture
    '{8'd7,  0,1,0,1, 3'd4, 0,0,0, 32'h0,         32'h0,        26'h0,       32'h0000_1234, 32'h0000_1234,32'h0}  // R7 conditional
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    applied++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    pcWrite = 0; pcWriteCond = 0; branchNe = 0; aluZero = 0; pcSrc = 3'd0;
    epcWrite = 0; causeWrite = 0; intCause = 1'b0;
    aluResult = '0; aluOut = '0; instrIndex = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
  endtask

  initial begin
    #1_000_000;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", pc, 32'h0, "reset pc");
    check("R1", epc, 32'h0, "reset epc");
    check("R1", cause, 32'h0, "reset cause");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      pcWrite = VEC[i].pw; pcWriteCond = VEC[i].cond; branchNe = VEC[i].ne;
      aluZero = VEC[i].zero; pcSrc = VEC[i].src; epcWrite = VEC[i].ew;
      causeWrite = VEC[i].cw; intCause = VEC[i].ic; aluResult = VEC[i].ar;
      aluOut = VEC[i].ao; instrIndex = VEC[i].idx;
      @(negedge clk);
      check($sformatf("R%0d v%0d", VEC[i].req, i), pc, VEC[i].expPc, "pc");
      check($sformatf("R%0d v%0d", VEC[i].req, i), epc, VEC[i].expEpc, "epc");
      check($sformatf("R%0d v%0d", VEC[i].req, i), cause, VEC[i].expCause, "cause");
    end

    // R10 overflow code again, upper bits stay zero
    idle(); causeWrite = 1; intCause = 1'b1;
    @(negedge clk);
    check("R10", cause, 32'h1, "overflow cause");

    // R1 reset wins over simultaneous loads
    idle(); rst = 1; pcWrite = 1; pcSrc = 3'd3; epcWrite = 1; causeWrite = 1;
    intCause = 1'b1; aluResult = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R1", pc, 32'h0, "reset priority pc");
    check("R1", epc, 32'h0, "reset priority epc");
    check("R1", cause, 32'h0, "reset priority cause");
    idle(); rst = 0;

    // R6 handler entry from reset state; R2 hold afterwards
    pcWrite = 1; pcSrc = 3'd3;
    @(negedge clk);
    check("R6", pc, 32'hC000_0000, "handler");
    idle(); aluResult = 32'h7777_0000;
    @(negedge clk);
    check("R2", pc, 32'hC000_0000, "idle hold");

    // R5 jump keeps handler upper bits
    pcWrite = 1; pcSrc = 3'd2; instrIndex = 26'h3FF_FFFF;
    @(negedge clk);
    check("R5", pc, 32'hCFFF_FFFC, "jump upper bits");
    idle();

    summary();
    $finish;
  end

endmodule